// File: doc/BRIEF.md
# Quad-Data-Rate Burst SRAM

This block is a synthesizable behavioural model of a static memory whose read and write data paths are separate and each move one word per half of the command clock. A read and a write can both be requested in the same command period. Each request carries a single address and moves a burst of two or four consecutive words. The command clock K is not a separate input. The block runs on a clock at twice the K rate, and a phase register inside the block marks which of its edges stand for K rising and which stand for K falling. The first edge after reset is always a K-rising edge.

The read burst starts after a fixed latency, set at build time in half-cycles (2, 3, 4 or 5, meaning 1, 1.5, 2 or 2.5 K cycles). A valid flag marks the half-cycles that carry read words. An echo strobe is high in the half-cycle that follows each K-rising edge, so read words line up with its edges. The address bus is shared between the two ports. The read address is taken at the K-rising edge and the write address at the K-falling edge that follows it. Write words arrive one K cycle after the write request.

Top module: `qdr_sram`

## Requirements
- R1: While reset is high at an edge of `clk2x`, `rvalid`, `rdata` and `echo_k` are 0 after that edge. The first `clk2x` edge with reset low is a K-rising edge, and after that the edge types alternate.
- R2: After every K-rising edge `echo_k` is 1. After every K-falling edge `echo_k` is 0.
- R3: A low `rd_sel_n` at a K-rising edge starts a read burst from the `addr` value at that edge. The burst returns BURST words, one per half-cycle, from addresses A, A+1, ... modulo 2^ADDR_W.
- R4: A low `wr_sel_n` at a K-rising edge starts a write burst. Its base address is the `addr` value at the next edge, which is K-falling. The `wdata` values at the 2nd, 3rd (and, for BURST=4, 4th and 5th) edges after the request are stored at base+0, +1, (+2, +3), modulo 2^ADDR_W.
- R5: Read word 0 appears on `rdata` after the edge RD_LAT_HALF half-cycles after the request edge. Each further word appears one half-cycle later.
- R6: `rvalid` is 1 after exactly those edges where a read word is placed on `rdata`, and 0 otherwise. `rdata` is 0 whenever `rvalid` is 0.
- R7: With BURST=2, a read and a write may both be started at every K-rising edge without either disturbing the other.
- R8: A read word holds every write word stored at an earlier edge, including words of a write still in progress. A word stored at the same edge as the read is not included.
- R9: With BURST=4, a select at the K-rising edge right after an accepted request on the same port is ignored. The other port is not affected by it.
- R10: Selects are sampled only at K-rising edges. Their values at K-falling edges have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Clock at twice the K rate. Alternate edges stand for K rising and K falling |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel_n | input | 1 | Active-low read request, sampled at K-rising edges |
| wr_sel_n | input | 1 | Active-low write request, sampled at K-rising edges |
| addr | input | ADDR_W | Shared address. Read base at K rising, write base at K falling |
| wdata | input | DATA_W | Write word, captured once per half-cycle during a write burst |
| rdata | output | DATA_W | Read word, one per half-cycle during a read burst |
| rvalid | output | 1 | High in half-cycles that carry a read word |
| echo_k | output | 1 | Strobe high in the half-cycle after each K-rising edge |

## Verification
The assertions assume that reset is held for at least one `clk2x` edge and that every input is stable around each `clk2x` edge. They also assume that the no-overlap checks are protected by the block's own burst-4 acceptance rule, not by polite stimulus. The bench drives all inputs on the falling edge of `clk2x`, so each value is settled well before the edge that samples it. On purpose, the bench issues back-to-back requests to the burst-4 builds. That way the ignore rule, and not the stimulus, keeps bursts from overlapping. The stimulus also toggles the selects during K-falling halves, and the bench checks that this has no effect. Four builds are exercised together: both burst lengths and the shortest and longest latencies.

// File: rtl/qdr_sram_pkg.sv
package qdr_sram_pkg;

    // Which K edge the next clk2x edge stands for.
    typedef enum logic {
        K_RISE_NEXT = 1'b0,
        K_FALL_NEXT = 1'b1
    } kphase_e;

    // A burst of 4 fills two K periods, so a port refuses a start
    // directly after one it has taken.
    function automatic logic start_allowed(input int burst, input logic taken_last);
        return (burst == 2) || !taken_last;
    endfunction

endpackage

// File: rtl/qdr_phase_gen.sv
module qdr_phase_gen
    import qdr_sram_pkg::*;
(
    input  logic clk2x,
    input  logic rst,
    output logic k_rise,
    output logic echo_q
);
    kphase_e ph;

    always_ff @(posedge clk2x) begin
        if (rst) begin
            ph     <= K_RISE_NEXT;
            echo_q <= 1'b0;
        end else begin
            ph     <= (ph == K_RISE_NEXT) ? K_FALL_NEXT : K_RISE_NEXT;
            echo_q <= (ph == K_RISE_NEXT);
        end
    end

    assign k_rise = !rst && (ph == K_RISE_NEXT);

    AST_ECHO_ALTERNATES: assert property (@(posedge clk2x) disable iff (rst)
        1'b1 |=> (echo_q != $past(echo_q)));  // R2

endmodule

// File: rtl/qdr_mem.sv
module qdr_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk2x,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wword,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rword
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk2x) begin
        if (we) cells[waddr] <= wword;
    end

    // Combinational read: a word stored at this edge is not yet visible.
    assign rword = cells[raddr];

endmodule

// File: rtl/qdr_wr_port.sv
module qdr_wr_port
    import qdr_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int BURST  = 2
) (
    input  logic              clk2x,
    input  logic              rst,
    input  logic              k_rise,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wword
);
    localparam int CW = $clog2(BURST);

    logic              pend;      // request taken, base address due next edge
    logic              arm;       // base held, first word due next edge
    logic              taken_last;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] ptr;
    logic [CW-1:0]     left;
    logic              take;

    assign take = k_rise && !wr_sel_n && start_allowed(BURST, taken_last);

    always_ff @(posedge clk2x) begin
        if (rst) begin
            pend       <= 1'b0;
            arm        <= 1'b0;
            taken_last <= 1'b0;
            base       <= '0;
            ptr        <= '0;
            left       <= '0;
        end else begin
            if (k_rise) taken_last <= take;
            pend <= take;
            arm  <= pend;
            if (pend) base <= addr;
            if (arm) begin
                ptr  <= base + ADDR_W'(1);
                left <= CW'(BURST - 1);
            end else if (left != '0) begin
                ptr  <= ptr + ADDR_W'(1);
                left <= left - CW'(1);
            end
        end
    end

    assign mem_we    = arm || (left != '0);
    assign mem_waddr = arm ? base : ptr;
    assign mem_wword = wdata;

    AST_WR_ADDR_ON_FALL: assert property (@(posedge clk2x) disable iff (rst)
        pend |-> !k_rise);  // R4
    AST_WR_NO_OVERLAP: assert property (@(posedge clk2x) disable iff (rst)
        arm |-> (left == '0));  // R9

endmodule

// File: rtl/qdr_rd_port.sv
module qdr_rd_port
    import qdr_sram_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int BURST       = 2,
    parameter int RD_LAT_HALF = 3
) (
    input  logic              clk2x,
    input  logic              rst,
    input  logic              k_rise,
    input  logic              rd_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] rword,
    output logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int CW = $clog2(BURST);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] a;
    } rreq_t;

    rreq_t             pipe [RD_LAT_HALF];
    logic              taken_last;
    logic [ADDR_W-1:0] ptr;
    logic [CW-1:0]     left;
    logic              take;
    logic              launch;
    logic              emit;

    assign take   = k_rise && !rd_sel_n && start_allowed(BURST, taken_last);
    assign launch = pipe[RD_LAT_HALF-1].vld;
    assign emit   = launch || (left != '0);
    assign raddr  = launch ? pipe[RD_LAT_HALF-1].a : ptr;

    always_ff @(posedge clk2x) begin
        if (rst) begin
            for (int i = 0; i < RD_LAT_HALF; i++) begin
                pipe[i].vld <= 1'b0;
                pipe[i].a   <= '0;
            end
            taken_last <= 1'b0;
            ptr        <= '0;
            left       <= '0;
            rdata      <= '0;
            rvalid     <= 1'b0;
        end else begin
            if (k_rise) taken_last <= take;
            pipe[0].vld <= take;
            pipe[0].a   <= addr;
            for (int i = 1; i < RD_LAT_HALF; i++) pipe[i] <= pipe[i-1];
            if (launch) begin
                ptr  <= pipe[RD_LAT_HALF-1].a + ADDR_W'(1);
                left <= CW'(BURST - 1);
            end else if (left != '0) begin
                ptr  <= ptr + ADDR_W'(1);
                left <= left - CW'(1);
            end
            rvalid <= emit;
            rdata  <= emit ? rword : '0;
        end
    end

    AST_RD_REQ_ON_RISE: assert property (@(posedge clk2x) disable iff (rst)
        pipe[0].vld |-> !k_rise);  // R10
    AST_RD_NO_OVERLAP: assert property (@(posedge clk2x) disable iff (rst)
        launch |-> (left == '0));  // R9

endmodule

// File: rtl/qdr_sram.sv
module qdr_sram
    import qdr_sram_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int BURST       = 2,
    parameter int RD_LAT_HALF = 3
) (
    input  logic              clk2x,
    input  logic              rst,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              echo_k
);
    logic              k_rise;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wword;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rword;

    qdr_phase_gen u_phase (
        .clk2x (clk2x),
        .rst   (rst),
        .k_rise(k_rise),
        .echo_q(echo_k)
    );

    qdr_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST(BURST)) u_wr (
        .clk2x    (clk2x),
        .rst      (rst),
        .k_rise   (k_rise),
        .wr_sel_n (wr_sel_n),
        .addr     (addr),
        .wdata    (wdata),
        .mem_we   (mem_we),
        .mem_waddr(mem_waddr),
        .mem_wword(mem_wword)
    );

    qdr_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk2x(clk2x),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wword(mem_wword),
        .raddr(mem_raddr),
        .rword(mem_rword)
    );

    qdr_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST(BURST),
                  .RD_LAT_HALF(RD_LAT_HALF)) u_rd (
        .clk2x   (clk2x),
        .rst     (rst),
        .k_rise  (k_rise),
        .rd_sel_n(rd_sel_n),
        .addr    (addr),
        .rword   (mem_rword),
        .raddr   (mem_raddr),
        .rdata   (rdata),
        .rvalid  (rvalid)
    );

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk2x) disable iff (rst)
        !rvalid |-> (rdata == '0));  // R6

endmodule

// File: tb/qdr_sram_tb_top.sv
`timescale 1ns/1ps

module qdr_sram_tb_lane #(
    parameter int BURST = 2,
    parameter int LAT   = 3
) (
    input  logic        clk2x,
    input  logic        rst,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [5:0]  addr,
    input  logic [15:0] wdata,
    output int          n_chk,
    output int          n_err
);
    localparam int DEPTH = 64;

    logic [15:0] rdata;
    logic        rvalid;
    logic        echo_k;

    qdr_sram #(.ADDR_W(6), .DATA_W(16), .BURST(BURST), .RD_LAT_HALF(LAT)) dut_i (
        .clk2x   (clk2x),
        .rst     (rst),
        .rd_sel_n(rd_n),
        .wr_sel_n(wr_n),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .rvalid  (rvalid),
        .echo_k  (echo_k)
    );

    // Behavioural reference: a word store plus schedules keyed by edge number.
    logic [15:0] m_mem  [DEPTH];
    bit          m_known[DEPTH];
    int          m_wtime[DEPTH];
    int          rd_sched[int];
    int          wr_sched[int];
    int          e = 0;
    int          last_rd = -100;
    int          last_wr = -100;
    bit          wpend = 0;
    bit          seen_edge = 0;
    bit          in_rst = 0;
    bit          exp_v = 0, exp_echo = 0, exp_known = 0, exp_fwd = 0;
    logic [15:0] exp_d = '0;
    int          a;

    initial begin
        n_chk = 0;
        n_err = 0;
        for (int i = 0; i < DEPTH; i++) begin
            m_known[i] = 0;
            m_wtime[i] = -1000;
        end
    end

    always @(posedge clk2x) begin
        seen_edge = 1;
        if (rst) begin
            in_rst = 1;
            e = 0; last_rd = -100; last_wr = -100; wpend = 0;
            exp_v = 0; exp_echo = 0;
            rd_sched.delete();
            wr_sched.delete();
        end else begin
            in_rst = 0;
            exp_v = rd_sched.exists(e);
            if (exp_v) begin
                a = rd_sched[e];
                exp_known = m_known[a];
                exp_d = m_mem[a];
                exp_fwd = (e - m_wtime[a]) <= 8;
                rd_sched.delete(e);
            end
            if (wr_sched.exists(e)) begin
                a = wr_sched[e];
                m_mem[a] = wdata;
                m_known[a] = 1;
                m_wtime[a] = e;
                wr_sched.delete(e);
            end
            if (wpend) begin
                for (int i = 0; i < BURST; i++) wr_sched[e + 1 + i] = (int'(addr) + i) % DEPTH;
                wpend = 0;
            end
            exp_echo = (e % 2 == 0);
            if (e % 2 == 0) begin
                if (!rd_n && (BURST == 2 || e - last_rd >= 4)) begin
                    last_rd = e;
                    for (int i = 0; i < BURST; i++) rd_sched[e + LAT + i] = (int'(addr) + i) % DEPTH;
                end
                if (!wr_n && (BURST == 2 || e - last_wr >= 4)) begin
                    last_wr = e;
                    wpend = 1;
                end
            end
            e++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s lane B%0d/L%0d edge %0d: actual %h expected %h",
                     tag, BURST, LAT, e, act, exp);
        end
    endtask

    always @(negedge clk2x) begin
        if (seen_edge) begin
            if (in_rst) begin
                chk(rvalid == 1'b0 && rdata == '0 && echo_k == 1'b0, "R1 reset outputs",
                    int'({rvalid, echo_k, rdata}), 0);
            end else begin
                chk(echo_k == exp_echo, "R2 echo strobe", int'(echo_k), int'(exp_echo));
                chk(rvalid == exp_v,
                    (BURST == 4) ? "R5 R6 R9 R10 read valid" : "R5 R6 R7 R10 read valid",
                    int'(rvalid), int'(exp_v));
                if (exp_v && exp_known)
                    chk(rdata == exp_d, exp_fwd ? "R8 forwarded read data" : "R3 R4 read data",
                        int'(rdata), int'(exp_d));
                if (!exp_v)
                    chk(rdata == '0, "R6 idle data", int'(rdata), 0);
            end
        end
    end

endmodule

module qdr_sram_tb_top;
    logic        clk2x = 1'b0;
    logic        rst = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = 16'h0;
    bit          done = 0;
    int          c0, e0, c1, e1, c2, e2, c3, e3;
    int          wd_err = 0;

    always #2.5 clk2x = ~clk2x;

    always @(negedge clk2x) wdata <= wdata + 16'h1357;

    qdr_sram_tb_lane #(.BURST(2), .LAT(3)) lane_b2_l3 (.clk2x(clk2x), .rst(rst), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .n_chk(c0), .n_err(e0));
    qdr_sram_tb_lane #(.BURST(4), .LAT(4)) lane_b4_l4 (.clk2x(clk2x), .rst(rst), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .n_chk(c1), .n_err(e1));
    qdr_sram_tb_lane #(.BURST(2), .LAT(2)) lane_b2_l2 (.clk2x(clk2x), .rst(rst), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .n_chk(c2), .n_err(e2));
    qdr_sram_tb_lane #(.BURST(4), .LAT(5)) lane_b4_l5 (.clk2x(clk2x), .rst(rst), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .n_chk(c3), .n_err(e3));

    // One K period, entered at the clk2x falling edge before a K-rising edge.
    // During the K-falling half the selects are set to fall_sel (R10).
    task automatic kcyc(input bit r, input bit w, input logic [5:0] ra, input logic [5:0] wa,
                        input bit fall_sel = 0);
        rd_n = !r; wr_n = !w; addr = ra;
        @(negedge clk2x);
        rd_n = !fall_sel; wr_n = !fall_sel; addr = wa;
        @(negedge clk2x);
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors",
                 c0 + c1 + c2 + c3 + wd_err, e0 + e1 + e2 + e3 + wd_err);
    endtask

    initial begin
        repeat (6) @(negedge clk2x);
        rst = 1'b0;
        // R4: fill the whole store, a write every other K cycle
        for (int a = 0; a < 64; a += 2) begin
            kcyc(0, 1, 6'd0, 6'(a));
            kcyc(0, 0, 6'd0, 6'd0);
        end
        repeat (4) kcyc(0, 0, 6'd0, 6'd0);
        // R3 R5 R7 R9: read and write at every K-rising edge
        for (int i = 0; i < 40; i++) kcyc(1, 1, 6'(i * 3), 6'(i * 5 + 1));
        repeat (4) kcyc(0, 0, 6'd0, 6'd0);
        // R8: read the cycle after a write to the same base, and in the same cycle
        kcyc(0, 1, 6'd0, 6'd10);
        kcyc(1, 0, 6'd10, 6'd0);
        repeat (3) kcyc(0, 0, 6'd0, 6'd0);
        kcyc(1, 1, 6'd20, 6'd20);
        kcyc(0, 0, 6'd0, 6'd0);
        kcyc(1, 0, 6'd20, 6'd0);
        repeat (3) kcyc(0, 0, 6'd0, 6'd0);
        // R3 R4: bursts that wrap past the top address
        kcyc(0, 1, 6'd0, 6'd63);
        kcyc(0, 0, 6'd0, 6'd0);
        kcyc(1, 0, 6'd62, 6'd0);
        repeat (3) kcyc(0, 0, 6'd0, 6'd0);
        // R10: selects held low only during K-falling halves
        repeat (6) kcyc(0, 0, 6'd5, 6'd7, 1);
        repeat (3) kcyc(0, 0, 6'd0, 6'd0);
        // mixed traffic
        for (int i = 0; i < 400; i++)
            kcyc(bit'($urandom % 2), bit'($urandom % 2), 6'($urandom), 6'($urandom), bit'($urandom % 2));
        repeat (8) kcyc(0, 0, 6'd0, 6'd0);
        done = 1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk2x);
        if (!done) begin
            wd_err = 1;
            $display("FAIL watchdog: actual running expected finished");
            report();
            $finish;
        end
    end

endmodule